// File: doc/BRIEF.md
# Encoder-Locked Sample Strobe Generator

This block is an all-digital phase-locked loop. It turns a slow shaft-encoder pulse train into an ADC sample strobe that runs at N times the encoder rate, so samples fall at fixed shaft angles whatever the rotation speed. The controlled oscillator is a phase accumulator clocked by the system clock. Its carry-out is the oscillator "tick". A phase detector counts ticks between successive encoder edges and compares that count with the expected value M·N. The signed difference drives a proportional-plus-integral filter, which sets the accumulator's tuning word.

The user programs N. The block chooses the M divider itself as a power of two, so that each reference period always spans enough ticks for fine error resolution. Dividing the ticks by M gives N strobes per encoder period. Strobes are released only while the loop reports lock. A sticky flag records any loss of lock during a run. Two statistics are exposed: the peak error magnitude and the number of measured periods. Dropping `run` clears everything and reloads the loop.

Top module: `enc_lock_pll`

## Requirements
- R1: The M divider is 2^k, where k is the smallest value in 0..MLOG_MAX with N·2^k ≥ MIN_COUNT. If no such k exists, k = MLOG_MAX. One sample strobe is produced for every M oscillator ticks.
- R2: The phase error is the number of ticks counted from one synchronized encoder rising edge up to the next, minus M·N. A tick that falls in the cycle of an edge belongs to the new period. The first edge after `run` rises only starts the count and yields no error.
- R3: On each new error e, the integrator becomes clamp(I − ki·e). The tuning word becomes clamp(I_new − kp·e). Both are clamped to [tw_lo, tw_hi]. While `run` is low, both hold floor((tw_lo+tw_hi)/2).
- R4: A tick occurs in each cycle in which the PHW-bit accumulator, adding the tuning word, carries out. A constant word W therefore gives a tick every 2^PHW/W cycles when W divides 2^PHW.
- R5: `locked` rises after LOCK_RUN consecutive errors whose magnitude is below `lock_thr`.
- R6: An error with magnitude ≥ `lock_thr` while locked clears `locked` and sets `lock_lost`. `lock_lost` stays set until `run` goes low.
- R7: `smp_strobe` pulses only while locked, for one clock per divider terminal count. No strobe appears while unlocked.
- R8: `err_peak` holds the largest error magnitude and `period_cnt` the number of errors measured since `run` rose. Both saturate.
- R9: While `run` is low, the flags, statistics, strobe, divider, accumulator and counters are all cleared.
- R10: With a nonzero integral gain and a reachable tuning word, the closed loop pulls in to lock. Once locked, it delivers N strobes per reference period, give or take one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Loop enable; low clears and reloads the loop |
| enc_in | input | 1 | Asynchronous encoder pulse input |
| n_div | input | NW | Strobes per encoder period (N) |
| kp | input | GW | Proportional gain |
| ki | input | GW | Integral gain |
| tw_lo | input | PHW | Lower tuning word limit |
| tw_hi | input | PHW | Upper tuning word limit |
| lock_thr | input | CW | Error magnitude bound for lock |
| smp_strobe | output | 1 | One-clock ADC sample strobe |
| locked | output | 1 | Loop lock indication |
| lock_lost | output | 1 | Sticky flag: lock was lost during this run |
| err_peak | output | CW | Peak error magnitude since run rose |
| period_cnt | output | CW | Measured reference periods since run rose |

## Verification
An encoder edge and an oscillator tick can land in the same clock. The tick must then open the new period rather than close the old one. The bench provokes this on every edge by choosing reference periods that are exact multiples of the tick spacing, with a fixed tuning word. The exact counts then make any tick assigned to the wrong period show up as a ±1 error in the peak statistic or as a spurious loss of lock. A second overlap is a lock-dropping error arriving while the divider is at terminal count. It is judged by requiring zero strobes over the unlocked window that follows.

// File: rtl/enc_lock_pll_pkg.sv
package enc_lock_pll_pkg;

   // state of the lock supervisor
   typedef enum logic {
      LK_HUNT = 1'b0,
      LK_HELD = 1'b1
   } lock_state_e;

   // width of an index able to hold 0..max_v
   function automatic int idx_width(input int max_v);
      return (max_v < 1) ? 1 : $clog2(max_v + 1);
   endfunction

endpackage

// File: rtl/encpll_phdet.sv
// Encoder synchronizer, automatic M selection and tick-counting phase detector.
module encpll_phdet
   import enc_lock_pll_pkg::*;
#(
   parameter int CW          = 20,
   parameter int NW          = 10,
   parameter int MLOG_MAX    = 8,
   parameter int MIN_COUNT   = 4096,
   parameter int SYNC_STAGES = 2,
   localparam int MLW        = idx_width(MLOG_MAX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 enc_in,
   input  logic                 tick,
   input  logic [NW-1:0]        n_div,
   output logic [MLW-1:0]       mlog,
   output logic signed [CW:0]   err,
   output logic                 err_vld
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   rise;
   logic [CW-1:0]          cnt_q;
   logic [CW-1:0]          mn;
   logic                   armed_q;
   logic [31:0]            n32;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], enc_in};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

   // smallest power-of-two M that gives at least MIN_COUNT ticks per period
   assign n32 = 32'(n_div);
   always_comb begin
      mlog = MLW'(MLOG_MAX);
      for (int k = MLOG_MAX; k >= 0; k--) begin
         if ((n32 << k) >= 32'(MIN_COUNT)) mlog = MLW'(k);
      end
   end

   assign mn = CW'(n_div) << mlog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         err     <= '0;
         err_vld <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         err     <= '0;
         err_vld <= 1'b0;
      end else begin
         err_vld <= 1'b0;
         if (rise) begin
            if (armed_q) begin
               err     <= $signed({1'b0, cnt_q}) - $signed({1'b0, mn});
               err_vld <= 1'b1;
            end
            armed_q <= 1'b1;
            cnt_q   <= tick ? CW'(1) : '0;
         end else if (tick && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/encpll_loopflt.sv
// Proportional-plus-integral loop filter with clamped integrator and tuning word.
module encpll_loopflt #(
   parameter int PHW       = 24,
   parameter int CW        = 20,
   parameter int GW        = 8,
   parameter bit PROP_PATH = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic signed [CW:0]  err,
   input  logic                err_vld,
   input  logic [GW-1:0]       kp,
   input  logic [GW-1:0]       ki,
   input  logic [PHW-1:0]      tw_lo,
   input  logic [PHW-1:0]      tw_hi,
   output logic [PHW-1:0]      tw
);

   localparam int WW = CW + GW + PHW + 4;

   logic signed [WW-1:0] err_w, ki_w, kp_w, lo_w, hi_w, integ_w, ig_raw, ig_new_w;
   logic [PHW:0]         lh_sum;
   logic [PHW-1:0]       mid;
   logic [PHW-1:0]       integ_q;
   logic [PHW-1:0]       integ_nx;
   logic [PHW-1:0]       tw_nx;

   function automatic logic [PHW-1:0] clamp_tw(input logic signed [WW-1:0] v,
                                               input logic signed [WW-1:0] lo,
                                               input logic signed [WW-1:0] hi);
      if (v < lo)      return lo[PHW-1:0];
      else if (v > hi) return hi[PHW-1:0];
      else             return v[PHW-1:0];
   endfunction

   assign err_w   = WW'(err);
   assign ki_w    = WW'(ki);
   assign kp_w    = WW'(kp);
   assign lo_w    = WW'(tw_lo);
   assign hi_w    = WW'(tw_hi);
   assign integ_w = WW'(integ_q);
   assign lh_sum  = {1'b0, tw_lo} + {1'b0, tw_hi};
   assign mid     = lh_sum[PHW:1];

   // a positive error means too many ticks: slow the oscillator
   assign ig_raw   = integ_w - (ki_w * err_w);
   assign integ_nx = clamp_tw(ig_raw, lo_w, hi_w);
   assign ig_new_w = WW'(integ_nx);

   generate
      if (PROP_PATH) begin : g_pi
         logic signed [WW-1:0] tw_raw;
         assign tw_raw = ig_new_w - (kp_w * err_w);
         assign tw_nx  = clamp_tw(tw_raw, lo_w, hi_w);
      end else begin : g_i_only
         assign tw_nx = integ_nx;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ_q <= '0;
         tw      <= '0;
      end else if (clr) begin
         integ_q <= mid;
         tw      <= mid;
      end else if (err_vld) begin
         integ_q <= integ_nx;
         tw      <= tw_nx;
      end
   end

endmodule

// File: rtl/encpll_nco.sv
// Phase-accumulator oscillator followed by the power-of-two M divider.
module encpll_nco
   import enc_lock_pll_pkg::*;
#(
   parameter int PHW      = 24,
   parameter int MLOG_MAX = 8,
   localparam int MLW     = idx_width(MLOG_MAX)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [PHW-1:0]  tw,
   input  logic [MLW-1:0]  mlog,
   input  logic            gate,
   output logic            tick,
   output logic            strobe
);

   logic [PHW-1:0]      acc_q;
   logic [PHW:0]        sum;
   logic [MLOG_MAX-1:0] mcnt_q;
   logic [MLOG_MAX-1:0] mmax;
   logic                term;

   assign sum = {1'b0, acc_q} + {1'b0, tw};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else if (clr) begin
         acc_q <= '0;
         tick  <= 1'b0;
      end else begin
         acc_q <= sum[PHW-1:0];
         tick  <= sum[PHW];
      end
   end

   assign mmax = MLOG_MAX'((32'd1 << mlog) - 32'd1);
   assign term = tick && (mcnt_q == mmax);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mcnt_q <= '0;
         strobe <= 1'b0;
      end else if (clr) begin
         mcnt_q <= '0;
         strobe <= 1'b0;
      end else begin
         strobe <= term && gate;
         if (tick) mcnt_q <= term ? '0 : mcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/encpll_lockmon.sv
// Lock supervisor, sticky loss flag and error statistics.
module encpll_lockmon
   import enc_lock_pll_pkg::*;
#(
   parameter int CW       = 20,
   parameter int LOCK_RUN = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic signed [CW:0]  err,
   input  logic                err_vld,
   input  logic [CW-1:0]       thr,
   output logic                locked,
   output logic                lost,
   output logic [CW-1:0]       peak,
   output logic [CW-1:0]       periods
);

   localparam int RW = idx_width(LOCK_RUN);

   lock_state_e    st_q;
   logic [RW-1:0]  run_q;
   logic [CW:0]    mag_w;
   logic [CW-1:0]  mag;
   logic           good;

   assign mag_w = err[CW] ? (~err + 1'b1) : err;
   assign mag   = mag_w[CW] ? '1 : mag_w[CW-1:0];
   assign good  = mag < thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= LK_HUNT;
         run_q   <= '0;
         lost    <= 1'b0;
         peak    <= '0;
         periods <= '0;
      end else if (clr) begin
         st_q    <= LK_HUNT;
         run_q   <= '0;
         lost    <= 1'b0;
         peak    <= '0;
         periods <= '0;
      end else if (err_vld) begin
         if (periods != '1) periods <= periods + 1'b1;
         if (mag > peak)    peak    <= mag;
         if (good) begin
            if (st_q == LK_HUNT) begin
               if (run_q == RW'(LOCK_RUN - 1)) begin
                  st_q  <= LK_HELD;
                  run_q <= '0;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end
         end else begin
            run_q <= '0;
            if (st_q == LK_HELD) begin
               st_q <= LK_HUNT;
               lost <= 1'b1;
            end
         end
      end
   end

   assign locked = (st_q == LK_HELD);

endmodule

// File: rtl/enc_lock_pll.sv
// Encoder-locked sample strobe PLL: top level.
module enc_lock_pll
   import enc_lock_pll_pkg::*;
#(
   parameter int PHW         = 24,
   parameter int CW          = 20,
   parameter int NW          = 10,
   parameter int GW          = 8,
   parameter int MIN_COUNT   = 4096,
   parameter int MLOG_MAX    = 8,
   parameter int LOCK_RUN    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PROP_PATH   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            enc_in,
   input  logic [NW-1:0]   n_div,
   input  logic [GW-1:0]   kp,
   input  logic [GW-1:0]   ki,
   input  logic [PHW-1:0]  tw_lo,
   input  logic [PHW-1:0]  tw_hi,
   input  logic [CW-1:0]   lock_thr,
   output logic            smp_strobe,
   output logic            locked,
   output logic            lock_lost,
   output logic [CW-1:0]   err_peak,
   output logic [CW-1:0]   period_cnt
);

   localparam int MLW = idx_width(MLOG_MAX);

   generate
      if (SYNC_STAGES < 2)          begin : g_chk_sync  $error("SYNC_STAGES must be at least 2"); end
      if (MLOG_MAX < 1)             begin : g_chk_mlog  $error("MLOG_MAX must be at least 1"); end
      if (NW + MLOG_MAX > CW)       begin : g_chk_cw    $error("CW too narrow for N times M"); end
      if (PHW < 4)                  begin : g_chk_phw   $error("PHW must be at least 4"); end
      if (LOCK_RUN < 2)             begin : g_chk_run   $error("LOCK_RUN must be at least 2"); end
   endgenerate

   logic                clr;
   logic                tick_w;
   logic [MLW-1:0]      mlog_w;
   logic signed [CW:0]  err_w;
   logic                err_vld_w;
   logic [PHW-1:0]      tw_w;

   assign clr = ~run;

   encpll_phdet #(
      .CW(CW), .NW(NW), .MLOG_MAX(MLOG_MAX), .MIN_COUNT(MIN_COUNT), .SYNC_STAGES(SYNC_STAGES)
   ) u_phdet (
      .clk(clk), .rst_n(rst_n), .clr(clr), .enc_in(enc_in), .tick(tick_w),
      .n_div(n_div), .mlog(mlog_w), .err(err_w), .err_vld(err_vld_w)
   );

   encpll_loopflt #(
      .PHW(PHW), .CW(CW), .GW(GW), .PROP_PATH(PROP_PATH)
   ) u_loopflt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .err(err_w), .err_vld(err_vld_w),
      .kp(kp), .ki(ki), .tw_lo(tw_lo), .tw_hi(tw_hi), .tw(tw_w)
   );

   encpll_nco #(
      .PHW(PHW), .MLOG_MAX(MLOG_MAX)
   ) u_nco (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tw(tw_w), .mlog(mlog_w),
      .gate(locked), .tick(tick_w), .strobe(smp_strobe)
   );

   encpll_lockmon #(
      .CW(CW), .LOCK_RUN(LOCK_RUN)
   ) u_lockmon (
      .clk(clk), .rst_n(rst_n), .clr(clr), .err(err_w), .err_vld(err_vld_w),
      .thr(lock_thr), .locked(locked), .lost(lock_lost),
      .peak(err_peak), .periods(period_cnt)
   );

endmodule

// File: rtl/enc_lock_pll_chk.sv
// Temporal checks for enc_lock_pll, attached by bind.
module enc_lock_pll_chk #(
   parameter int PHW = 24,
   parameter int CW  = 20
) (
   input logic            clk,
   input logic            rst_n,
   input logic            run,
   input logic            smp_strobe,
   input logic            locked,
   input logic            lock_lost,
   input logic [CW-1:0]   err_peak,
   input logic [CW-1:0]   period_cnt,
   input logic [PHW-1:0]  tw_lo,
   input logic [PHW-1:0]  tw_hi,
   input logic [PHW-1:0]  tw,
   input logic            err_vld
);

   AST_TW_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) && $stable(tw_lo) && $stable(tw_hi) && (tw_lo <= tw_hi)
      |-> (tw >= tw_lo) && (tw <= tw_hi)); // R3

   AST_LOCK_ON_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(err_vld)); // R5

   AST_DROP_MARKS_LOST: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) && $past(run) |-> lock_lost); // R6

   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) && $past(lock_lost) |-> lock_lost); // R6

   AST_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      smp_strobe |-> $past(locked)); // R7

   AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> err_peak >= $past(err_peak)); // R8

   AST_PERIODS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> (period_cnt == $past(period_cnt)) ||
                     (period_cnt == $past(period_cnt) + 1'b1)); // R8

   AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !locked && !lock_lost && !smp_strobe); // R9

endmodule

bind enc_lock_pll enc_lock_pll_chk #(.PHW(PHW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .smp_strobe(smp_strobe),
   .locked(locked), .lock_lost(lock_lost), .err_peak(err_peak),
   .period_cnt(period_cnt), .tw_lo(tw_lo), .tw_hi(tw_hi),
   .tw(tw_w), .err_vld(err_vld_w)
);

// File: tb/enc_lock_pll_bench.sv
module enc_lock_pll_bench;

   localparam int PHW = 8;
   localparam int CW  = 12;
   localparam int NW  = 6;
   localparam int GW  = 4;
   localparam int MINC = 16;
   localparam int MLX = 4;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic            rst_n = 1'b0;
   logic            run = 1'b0;
   logic            enc_in = 1'b0;
   logic [NW-1:0]   n_div = '0;
   logic [GW-1:0]   kp = '0;
   logic [GW-1:0]   ki = '0;
   logic [PHW-1:0]  tw_lo = '0;
   logic [PHW-1:0]  tw_hi = '0;
   logic [CW-1:0]   lock_thr = '0;
   logic            smp_strobe;
   logic            locked;
   logic            lock_lost;
   logic [CW-1:0]   err_peak;
   logic [CW-1:0]   period_cnt;

   enc_lock_pll #(
      .PHW(PHW), .CW(CW), .NW(NW), .GW(GW), .MIN_COUNT(MINC),
      .MLOG_MAX(MLX), .LOCK_RUN(8), .SYNC_STAGES(2), .PROP_PATH(1'b1)
   ) u_enc_lock_pll (
      .clk(clk), .rst_n(rst_n), .run(run), .enc_in(enc_in), .n_div(n_div),
      .kp(kp), .ki(ki), .tw_lo(tw_lo), .tw_hi(tw_hi), .lock_thr(lock_thr),
      .smp_strobe(smp_strobe), .locked(locked), .lock_lost(lock_lost),
      .err_peak(err_peak), .period_cnt(period_cnt)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   int last_t = 0;
   int last_gap = 0;
   int stb_cnt = 0;
   int rises = 0;
   bit done = 1'b0;

   // strobe monitor, sampled 1 ns after the active edge
   always @(posedge clk) begin
      #1;
      cyc++;
      if (smp_strobe === 1'b1) begin
         last_gap = cyc - last_t;
         last_t   = cyc;
         stb_cnt++;
      end
   end

   task automatic expect_eq(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_rng(input string tag, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic pulses(input int period, input int num);
      for (int p = 0; p < num; p++) begin
         @(negedge clk) enc_in = 1'b1;
         rises++;
         repeat (period / 2) @(negedge clk);
         enc_in = 1'b0;
         repeat (period - period / 2 - 1) @(negedge clk);
      end
   endtask

   task automatic configure(input int n, input int kpv, input int kiv,
                            input int lo, input int hi, input int thr);
      @(negedge clk);
      run      = 1'b0;
      enc_in   = 1'b0;
      n_div    = NW'(n);
      kp       = GW'(kpv);
      ki       = GW'(kiv);
      tw_lo    = PHW'(lo);
      tw_hi    = PHW'(hi);
      lock_thr = CW'(thr);
      repeat (4) @(negedge clk);
      rises = 0;
      run   = 1'b1;
   endtask

   task automatic strobe_gap(output int g);
      stb_cnt = 0;
      for (int i = 0; i < 600 && stb_cnt < 3; i++) @(negedge clk);
      g = (stb_cnt >= 3) ? last_gap : -1;
   endtask

   function automatic int m_of(input int n);
      for (int k = 0; k <= MLX; k++) if ((n << k) >= MINC) return (1 << k);
      return (1 << MLX);
   endfunction

   initial begin
      int g;
      int s0;
      int nlist [8] = '{1, 2, 3, 4, 5, 8, 16, 17};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9: idle state while run is low
      expect_eq("R9 reset locked", int'(locked), 0);
      expect_eq("R9 reset lock_lost", int'(lock_lost), 0);
      expect_eq("R9 reset err_peak", int'(err_peak), 0);
      expect_eq("R9 reset period_cnt", int'(period_cnt), 0);
      expect_eq("R9 reset strobes", stb_cnt, 0);

      // fixed word 64: one tick every 4 cycles; N=4 -> M=4, M*N=16
      configure(4, 0, 0, 64, 64, 2);
      stb_cnt = 0;
      pulses(64, 8);
      expect_eq("R5 not yet locked after 7 errors", int'(locked), 0);
      expect_eq("R7 no strobe before lock", stb_cnt, 0);
      pulses(64, 1);
      expect_eq("R5 locked after 8 good errors", int'(locked), 1);
      expect_eq("R2 exact period gives zero peak", int'(err_peak), 0);
      expect_eq("R8 period count", int'(period_cnt), rises - 1);
      s0 = stb_cnt;
      pulses(64, 4);
      expect_eq("R1 N strobes per period", stb_cnt - s0, 16);
      expect_eq("R1 strobe spacing 4*M", last_gap, 16);

      // +1 error stays inside threshold
      pulses(68, 1);
      pulses(64, 1);
      expect_eq("R5 small error keeps lock", int'(locked), 1);
      expect_eq("R2 peak after +1 error", int'(err_peak), 1);
      // +2 error breaks lock
      pulses(72, 1);
      pulses(64, 1);
      expect_eq("R6 lock dropped", int'(locked), 0);
      expect_eq("R6 lost flag set", int'(lock_lost), 1);
      expect_eq("R8 peak after +2", int'(err_peak), 2);
      stb_cnt = 0;
      pulses(64, 3);
      expect_eq("R7 no strobe while unlocked", stb_cnt, 0);
      pulses(64, 5);
      expect_eq("R5 relocked", int'(locked), 1);
      expect_eq("R6 lost stays sticky", int'(lock_lost), 1);
      pulses(60, 1);
      pulses(64, 1);
      expect_eq("R2 -1 error keeps lock", int'(locked), 1);
      expect_eq("R8 peak holds maximum", int'(err_peak), 2);
      expect_eq("R8 period count tracks edges", int'(period_cnt), rises - 1);

      // run low clears everything
      @(negedge clk) run = 1'b0;
      repeat (3) @(negedge clk);
      expect_eq("R9 clear locked", int'(locked), 0);
      expect_eq("R9 clear lost", int'(lock_lost), 0);
      expect_eq("R9 clear peak", int'(err_peak), 0);
      expect_eq("R9 clear periods", int'(period_cnt), 0);

      // R1 sweep of N with open loop, period 40 -> 10 ticks per period
      foreach (nlist[i]) begin
         configure(nlist[i], 0, 0, 64, 64, 4095);
         pulses(40, 9);
         expect_eq($sformatf("R5 sweep N=%0d locked", nlist[i]), int'(locked), 1);
         expect_eq($sformatf("R2 sweep N=%0d peak", nlist[i]), int'(err_peak),
                   (nlist[i] * m_of(nlist[i]) > 10) ? nlist[i] * m_of(nlist[i]) - 10
                                                    : 10 - nlist[i] * m_of(nlist[i]));
         strobe_gap(g);
         expect_eq($sformatf("R1 sweep N=%0d gap", nlist[i]), g, 4 * m_of(nlist[i]));
      end

      // R3 clamp at the lower limit: slow reference drives word to 32
      configure(4, 1, 2, 32, 64, 4095);
      pulses(400, 9);
      strobe_gap(g);
      expect_eq("R3 word clamped to low limit (gap)", g, 32);
      // R3 clamp at the upper limit: fast reference drives word to 64
      configure(4, 1, 2, 32, 64, 4095);
      pulses(20, 9);
      strobe_gap(g);
      expect_eq("R4 word clamped to high limit (gap)", g, 16);

      // R10 closed loop pull-in from word 48 to 64
      configure(4, 0, 1, 16, 80, 2);
      for (int i = 0; i < 150 && !locked; i++) pulses(64, 1);
      expect_eq("R10 loop pulls in", int'(locked), 1);
      s0 = stb_cnt;
      pulses(64, 8);
      expect_rng("R10 strobes over 8 periods", stb_cnt - s0, 31, 33);
      expect_eq("R10 lock held", int'(locked), 1);
      expect_eq("R10 no loss during tracking", int'(lock_lost), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R10 actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule